// File: doc/BRIEF.md
# USART SPI Master Controller

This block is a serial port whose only supported operating mode here is synchronous SPI master. A host programs it through a small register bus: a data register, a status register, two control registers and a baud divider. Writing the data register loads a one-byte transmit holding buffer. From there the byte moves into a shift register, which drives it out on MOSI while SCK toggles. The MISO line is sampled on the opposite SCK edges, and the received byte lands in the receive buffer.

Because the transmit side is double-buffered, a second byte can be written while the first is still shifting, and the two go out back to back. SCK polarity, clock phase and bit order come from control register C. The mode field in that register must select SPI master before any clocking happens.

Turning the transmitter off is deferred until nothing is left to send. Turning the receiver off discards the received byte. Two interrupt requests are produced: transfer-complete and buffer-empty. Each is gated by its own enable bit and by a global interrupt enable input.

Register addresses on `bus_addr`:
- 0: data. A write fills the transmit buffer; a read returns the received byte.
- 1: status. Bit 7 is receive-complete, bit 6 is transfer-complete, bit 5 is buffer-empty.
- 2: control B. Bit 6 is the transfer-complete interrupt enable, bit 5 the buffer-empty interrupt enable, bit 4 the receiver enable and bit 3 the transmitter enable.
- 3: control C. Bits 7:6 are the mode, bit 2 selects LSB first, bit 1 is the phase and bit 0 the polarity.
- 4: divider.

Reads return data one clock after `bus_re`.

Top module: `spim_usart`

## Requirements
- R1: After reset, control C reads 0x06 (mode 00, LSB-first 1, phase 1, polarity 0), control B reads 0x00, status reads 0x20 (only bit 5, buffer empty, set) and the divider reads 0x00. SCK, `pin_oe`, `irq_tc` and `irq_de` are low.
- R2: Control C bits 5:3 always read 0, and control B bits 7 and 2:0 always read 0. Writing 0xFF makes control C read 0xC7 and control B read 0x78.
- R3: SCK toggles and the buffer drains only when control C[7:6] = 11 and the transmitter is active. With only the receiver enabled (B[4]=1, B[3]=0), or with any other mode value, a written byte stays in the buffer (status bit 5 = 0) and SCK does not move.
- R4: SCK rests at the level of C[0] between bytes. Each byte produces exactly 16 SCK transitions, and consecutive transitions within a byte are spaced divider+1 clocks apart.
- R5: MOSI sends the byte LSB first when C[2]=1 and MSB first when C[2]=0. Each bit is stable at the sampling edge: the leading SCK edge when C[1]=0, the trailing edge when C[1]=1.
- R6: MISO is sampled on those same edges, in the same bit order. At the end of the byte the received value is readable at address 0 and status bit 7 sets. A read of address 0 clears status bit 7.
- R7: Status bit 5 clears when address 0 is written and sets when the buffer moves into the shift register. A byte written while another is shifting is sent right after it.
- R8: Status bit 6 sets when the last bit of a byte completes with the buffer empty. Writing a 1 to status bit 6 clears it.
- R9: `irq_tc` is high only while control B[6], `gie` and status bit 6 are all set, and it follows them one clock later.
- R10: `irq_de` is high only while control B[5], `gie` and status bit 5 are all set, and it follows them one clock later.
- R11: Clearing B[3] during a transfer keeps `pin_oe` high and lets the byte finish. `pin_oe` falls once both the shift register and the buffer are empty.
- R12: Clearing B[4] empties the receive buffer: status bit 7 reads 0 and address 0 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gie | input | 1 | Global interrupt enable |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one clock after `bus_re` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| pin_oe | output | 1 | Transmitter owns the serial pins |
| irq_tc | output | 1 | Transfer-complete interrupt request |
| irq_de | output | 1 | Buffer-empty interrupt request |

## Verification
The assertions check the following on every cycle:
- a byte starts only from SPI master mode with the transmitter active, and the buffer is empty from that start onward;
- SCK stays at the polarity level while idle;
- the transmitter releases its pins only once nothing is pending;
- the reserved bits read as zero, transfer-complete clears when written, and a disabled receiver holds no received flag;
- either interrupt is off whenever the global enable is off.

Bit order, phase placement, divider spacing, the received value and back-to-back double buffering appear only in the bench's sweep over all eight clocking configurations. That bench decodes MOSI at the sampling edges and loops MOSI back to MISO, either inverted or straight.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int REG_W = 8;

  typedef enum logic [2:0] {
    A_DATA = 3'd0,
    A_STAT = 3'd1,
    A_CTLB = 3'd2,
    A_CTLC = 3'd3,
    A_DIV  = 3'd4
  } spim_addr_e;

  localparam logic [1:0] MODE_SPIM = 2'b11;

  localparam int ST_RXC = 7;
  localparam int ST_TXC = 6;
  localparam int ST_DRE = 5;

  localparam logic [REG_W-1:0] CTLC_RST = 8'h06;
endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spim_engine.sv
module spim_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              tick,
  input  logic              miso,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int CNT_W = $clog2(2 * DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(2 * DATA_W - 1);

  logic [DATA_W-1:0] tx_sh, rx_sh, tx_nxt, rx_nxt;
  logic [CNT_W-1:0]  h;
  logic              pha_q, lsb_q;
  logic              lead, smp, shift_en;

  // even half-period index = leading edge, odd = trailing edge
  assign lead     = ~h[0];
  assign smp      = lead ^ pha_q;
  assign shift_en = !smp && !(pha_q && (h == '0));

  always_comb begin
    if (lsb_q) tx_nxt = {1'b0, tx_sh[DATA_W-1:1]};
    else       tx_nxt = {tx_sh[DATA_W-2:0], 1'b0};
    if (!smp)       rx_nxt = rx_sh;
    else if (lsb_q) rx_nxt = {miso, rx_sh[DATA_W-1:1]};
    else            rx_nxt = {rx_sh[DATA_W-2:0], miso};
  end

  assign mosi = lsb_q ? tx_sh[0] : tx_sh[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      sck     <= 1'b0;
      done    <= 1'b0;
      h       <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_byte <= '0;
      pha_q   <= 1'b0;
      lsb_q   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sck <= cpol;
        if (start) begin
          busy  <= 1'b1;
          tx_sh <= tx_byte;
          h     <= '0;
          pha_q <= cpha;
          lsb_q <= lsb;
        end
      end else if (tick) begin
        sck   <= ~sck;
        h     <= h + 1'b1;
        rx_sh <= rx_nxt;
        if (shift_en) tx_sh <= tx_nxt;
        if (h == LAST) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_byte <= rx_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gie,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic [2:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             busy,
  input  logic             done,
  input  logic [REG_W-1:0] rx_byte,
  output logic             start,
  output logic [REG_W-1:0] tx_byte,
  output logic [1:0]       mode,
  output logic             lsb,
  output logic             cpha,
  output logic             cpol,
  output logic [DIV_W-1:0] div,
  output logic             pin_oe,
  output logic             irq_tc,
  output logic             irq_de,
  output logic             buf_full,
  output logic             tx_done,
  output logic             rx_done,
  output logic             rx_en
);
  logic [REG_W-1:0] rx_buf;
  logic tc_ie, de_ie, tx_en, tx_act;
  logic wr_data, wr_stat, wr_ctlb, wr_ctlc, wr_div, rd_data;

  assign wr_data = bus_we && (bus_addr == A_DATA);
  assign wr_stat = bus_we && (bus_addr == A_STAT);
  assign wr_ctlb = bus_we && (bus_addr == A_CTLB);
  assign wr_ctlc = bus_we && (bus_addr == A_CTLC);
  assign wr_div  = bus_we && (bus_addr == A_DIV);
  assign rd_data = bus_re && (bus_addr == A_DATA);

  assign start  = (mode == MODE_SPIM) && tx_act && buf_full && !busy;
  assign pin_oe = tx_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_ie    <= 1'b0;
      de_ie    <= 1'b0;
      rx_en    <= 1'b0;
      tx_en    <= 1'b0;
      tx_act   <= 1'b0;
      mode     <= CTLC_RST[7:6];
      lsb      <= CTLC_RST[2];
      cpha     <= CTLC_RST[1];
      cpol     <= CTLC_RST[0];
      div      <= '0;
      tx_byte  <= '0;
      buf_full <= 1'b0;
      tx_done  <= 1'b0;
      rx_done  <= 1'b0;
      rx_buf   <= '0;
      irq_tc   <= 1'b0;
      irq_de   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (wr_ctlb) {tc_ie, de_ie, rx_en, tx_en} <= bus_wdata[6:3];
      if (wr_ctlc) begin
        mode <= bus_wdata[7:6];
        {lsb, cpha, cpol} <= bus_wdata[2:0];
      end
      if (wr_div) div <= bus_wdata[DIV_W-1:0];

      // disable waits until nothing is left to send
      tx_act <= tx_en || (tx_act && (busy || buf_full));

      if (start) begin
        buf_full <= 1'b0;
      end else if (wr_data && !buf_full) begin
        tx_byte  <= bus_wdata;
        buf_full <= 1'b1;
      end

      if (done && !buf_full) tx_done <= 1'b1;
      else if (wr_stat && bus_wdata[ST_TXC]) tx_done <= 1'b0;

      if (!rx_en) begin
        rx_buf  <= '0;
        rx_done <= 1'b0;
      end else if (done) begin
        rx_buf  <= rx_byte;
        rx_done <= 1'b1;
      end else if (rd_data) begin
        rx_done <= 1'b0;
      end

      irq_tc <= tc_ie && gie && tx_done;
      irq_de <= de_ie && gie && !buf_full;

      if (bus_re) begin
        case (bus_addr)
          A_DATA:  bus_rdata <= rx_buf;
          A_STAT:  bus_rdata <= {rx_done, tx_done, !buf_full, 5'b0};
          A_CTLB:  bus_rdata <= {1'b0, tc_ie, de_ie, rx_en, tx_en, 3'b0};
          A_CTLC:  bus_rdata <= {mode, 3'b0, lsb, cpha, cpol};
          A_DIV:   bus_rdata <= REG_W'(div);
          default: bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/spim_usart.sv
module spim_usart
  import spim_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gie,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic [2:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic             pin_oe,
  output logic             irq_tc,
  output logic             irq_de
);
  localparam int DATA_W = REG_W;

  logic              eng_busy, eng_done, eng_start, baud_tick;
  logic [DATA_W-1:0] eng_rx, eng_tx;
  logic [1:0]        cfg_mode;
  logic              cfg_lsb, cfg_cpha, cfg_cpol;
  logic [DIV_W-1:0]  cfg_div;
  logic              buf_full, tx_done, rx_done, rx_en;

  spim_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .gie(gie),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(eng_busy), .done(eng_done), .rx_byte(eng_rx),
    .start(eng_start), .tx_byte(eng_tx),
    .mode(cfg_mode), .lsb(cfg_lsb), .cpha(cfg_cpha), .cpol(cfg_cpol),
    .div(cfg_div), .pin_oe(pin_oe), .irq_tc(irq_tc), .irq_de(irq_de),
    .buf_full(buf_full), .tx_done(tx_done), .rx_done(rx_done), .rx_en(rx_en)
  );

  spim_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .run(eng_busy), .div(cfg_div), .tick(baud_tick)
  );

  spim_engine #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst(rst), .start(eng_start), .tick(baud_tick), .miso(miso),
    .cpol(cfg_cpol), .cpha(cfg_cpha), .lsb(cfg_lsb), .tx_byte(eng_tx),
    .busy(eng_busy), .sck(sck), .mosi(mosi), .done(eng_done), .rx_byte(eng_rx)
  );
endmodule

// File: rtl/spim_usart_chk.sv
module spim_usart_chk (
  input logic       clk,
  input logic       rst,
  input logic       gie,
  input logic       bus_re,
  input logic       bus_we,
  input logic [2:0] bus_addr,
  input logic       wr_tc_bit,
  input logic [2:0] rd_resv,
  input logic       pin_oe,
  input logic       sck,
  input logic       irq_tc,
  input logic       irq_de,
  input logic       busy,
  input logic       done,
  input logic       buf_full,
  input logic       tx_done,
  input logic       rx_done,
  input logic       rx_en,
  input logic       cpol,
  input logic [1:0] mode
);
  p_resv_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == 3'd3) |=> (rd_resv == 3'b000));

  p_start_gate_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(mode == 2'b11 && pin_oe));

  p_sck_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sck == cpol));

  p_dre_on_load_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !buf_full);

  p_tc_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 3'd1 && wr_tc_bit && !done) |=> !tx_done);

  p_irq_tc_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !gie |=> !irq_tc);

  p_irq_de_gate_r10: assert property (@(posedge clk) disable iff (rst)
    !gie |=> !irq_de);

  p_oe_defer_r11: assert property (@(posedge clk) disable iff (rst)
    (pin_oe && (busy || buf_full)) |=> pin_oe);

  p_rx_flush_r12: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !rx_done);
endmodule

bind spim_usart spim_usart_chk u_chk (
  .clk(clk), .rst(rst), .gie(gie), .bus_re(bus_re), .bus_we(bus_we),
  .bus_addr(bus_addr), .wr_tc_bit(bus_wdata[6]), .rd_resv(bus_rdata[5:3]),
  .pin_oe(pin_oe), .sck(sck), .irq_tc(irq_tc), .irq_de(irq_de),
  .busy(eng_busy), .done(eng_done), .buf_full(buf_full), .tx_done(tx_done),
  .rx_done(rx_done), .rx_en(rx_en), .cpol(cfg_cpol), .mode(cfg_mode)
);

// File: tb/tb_spim_usart.sv
`timescale 1ns/1ps
module tb_spim_usart;
  logic clk = 1'b0, rst = 1'b1, gie = 1'b0, bus_we = 1'b0, bus_re = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic sck, mosi, miso, pin_oe, irq_tc, irq_de;
  logic inv = 1'b0;

  assign miso = mosi ^ inv;

  spim_usart dut (
    .clk(clk), .rst(rst), .gie(gie), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .pin_oe(pin_oe),
    .irq_tc(irq_tc), .irq_de(irq_de)
  );

  always #2.5 clk = ~clk;

  int nchk = 0, nerr = 0;

  // SCK / MOSI observer
  logic m_pol = 1'b0, m_pha = 1'b0, cur_lsb = 1'b0, prev_sck = 1'b0;
  int m_tog = 0, m_gap = 0, m_bad = 0, m_n = 0, m_div = 0;
  logic [31:0] m_bits = '0;

  always @(negedge clk) begin
    m_gap++;
    if (sck !== prev_sck) begin
      if (m_tog > 0 && m_gap != m_div + 1) m_bad++;
      if ((sck != m_pol) != m_pha) begin
        if (m_n < 32) m_bits[m_n] = mosi;
        m_n++;
      end
      m_tog++;
      m_gap = 0;
    end
    prev_sck = sck;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic mclr();
    @(posedge clk); #1;
    m_tog = 0; m_gap = 0; m_bad = 0; m_n = 0; m_bits = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic poll(input int bitn, output bit ok);
    logic [7:0] s;
    ok = 1'b0;
    for (int i = 0; i < 500; i++) begin
      rd(3'd1, s);
      if (s[bitn]) begin ok = 1'b1; break; end
    end
  endtask

  function automatic logic [7:0] decode(input int base, input logic lsbf);
    logic [7:0] g;
    for (int i = 0; i < 8; i++) g[lsbf ? i : 7 - i] = m_bits[base + i];
    return g;
  endfunction

  task automatic xfer(input logic [7:0] b, input logic iv, input bit do_read);
    logic [7:0] s, d, g;
    bit ok;
    inv = iv;
    mclr();
    wr(3'd1, 8'h40);
    wr(3'd0, b);
    poll(7, ok);
    chk(ok, "R6 receive flag set", ok, 1);
    chk(m_tog == 16, "R4 transitions per byte", m_tog, 16);
    chk(m_bad == 0, "R4 half-period spacing", m_bad, 0);
    g = decode(0, cur_lsb);
    chk(g == b, "R5 MOSI order/phase", g, b);
    rd(3'd1, s);
    chk(s[6] == 1'b1, "R8 transfer-complete set", s, 8'h40);
    chk(sck == m_pol, "R4 SCK idle level", sck, m_pol);
    if (do_read) begin
      rd(3'd0, d);
      chk(d == (b ^ {8{iv}}), "R6 received byte", d, b ^ {8{iv}});
      rd(3'd1, s);
      chk(s[7] == 1'b0, "R6 flag cleared by read", s[7], 0);
    end
  endtask

  function automatic logic [7:0] pat(input int j);
    case (j)
      0: return 8'hA5;
      1: return 8'h01;
      2: return 8'h80;
      default: return 8'h3C;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] s, d, g;
    bit ok;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(sck == 0 && pin_oe == 0, "R1 pins low", {sck, pin_oe}, 0);
    chk(irq_tc == 0 && irq_de == 0, "R1 irqs low", {irq_tc, irq_de}, 0);
    rd(3'd3, d); chk(d == 8'h06, "R1 control C", d, 8'h06);
    rd(3'd2, d); chk(d == 8'h00, "R1 control B", d, 8'h00);
    rd(3'd1, d); chk(d == 8'h20, "R1 status", d, 8'h20);
    rd(3'd4, d); chk(d == 8'h00, "R1 divider", d, 8'h00);

    // R2 reserved bits
    wr(3'd3, 8'hFF); rd(3'd3, d); chk(d == 8'hC7, "R2 control C", d, 8'hC7);
    wr(3'd2, 8'hFF); rd(3'd2, d); chk(d == 8'h78, "R2 control B", d, 8'h78);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'hC0);
    repeat (4) @(negedge clk);

    // R3 no clocking without transmitter or without SPI mode
    m_pol = 0; m_pha = 0; cur_lsb = 0; inv = 0;
    wr(3'd2, 8'h10);
    mclr();
    wr(3'd0, 8'h55);
    repeat (60) @(negedge clk);
    chk(m_tog == 0, "R3 receiver only gives no SCK", m_tog, 0);
    rd(3'd1, s); chk(s[5] == 0, "R3 byte held in buffer", s, 8'h00);
    chk(pin_oe == 0, "R3 pins not owned", pin_oe, 0);
    wr(3'd3, 8'h00);
    wr(3'd2, 8'h18);
    repeat (60) @(negedge clk);
    chk(m_tog == 0, "R3 non-SPI mode gives no SCK", m_tog, 0);
    wr(3'd3, 8'hC0);
    poll(7, ok);
    chk(ok && m_tog == 16, "R3 transfer after SPI mode set", m_tog, 16);
    rd(3'd0, d); chk(d == 8'h55, "R3 byte delivered", d, 8'h55);

    // R4 R5 R6 R8 sweep over all clocking configurations
    for (int k = 0; k < 8; k++) begin
      m_pol = k[0]; m_pha = k[1]; cur_lsb = k[2];
      wr(3'd3, 8'hC0 | 8'(k));
      for (int v = 0; v < 2; v++) begin
        m_div = v * 2;
        wr(3'd4, 8'(m_div));
        repeat (3) @(negedge clk);
        for (int j = 0; j < 4; j++) xfer(pat(j), j[0], 1'b1);
      end
    end

    // R7 double buffering
    m_pol = 0; m_pha = 0; cur_lsb = 0; inv = 0; m_div = 2;
    wr(3'd3, 8'hC0); wr(3'd4, 8'd2);
    repeat (3) @(negedge clk);
    mclr();
    wr(3'd1, 8'h40);
    wr(3'd0, 8'hC3);
    poll(5, ok);
    chk(ok, "R7 buffer-empty after load", ok, 1);
    rd(3'd1, s); chk(s[6] == 0, "R8 not set mid-byte", s, 0);
    wr(3'd0, 8'h5A);
    rd(3'd1, s); chk(s[5] == 0, "R7 buffer full while shifting", s, 0);
    poll(6, ok);
    chk(m_tog == 32, "R7 two bytes back to back", m_tog, 32);
    g = decode(0, 1'b0); chk(g == 8'hC3, "R7 first byte", g, 8'hC3);
    g = decode(8, 1'b0); chk(g == 8'h5A, "R7 second byte", g, 8'h5A);
    rd(3'd0, d); chk(d == 8'h5A, "R7 last received", d, 8'h5A);

    // R8 clear
    wr(3'd1, 8'h40); rd(3'd1, s); chk(s[6] == 0, "R8 write-one clears", s, 0);

    // R12 receiver disable flushes
    xfer(8'h96, 1'b0, 1'b0);
    wr(3'd2, 8'h08);
    rd(3'd1, s); chk(s[7] == 0, "R12 flag flushed", s, 0);
    rd(3'd0, d); chk(d == 8'h00, "R12 buffer flushed", d, 0);
    wr(3'd2, 8'h18);
    rd(3'd1, s); chk(s[7] == 0, "R12 stays empty", s, 0);

    // R9 R10 interrupt gating
    gie = 0;
    wr(3'd2, 8'h78);
    xfer(8'h3C, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    chk(irq_tc == 0, "R9 global enable off", irq_tc, 0);
    chk(irq_de == 0, "R10 global enable off", irq_de, 0);
    gie = 1;
    repeat (2) @(negedge clk);
    chk(irq_tc == 1, "R9 request raised", irq_tc, 1);
    chk(irq_de == 1, "R10 request raised", irq_de, 1);
    wr(3'd1, 8'h40);
    repeat (2) @(negedge clk);
    chk(irq_tc == 0, "R9 drops with flag", irq_tc, 0);
    wr(3'd2, 8'h58);
    repeat (2) @(negedge clk);
    chk(irq_de == 0, "R10 drops with enable", irq_de, 0);
    gie = 0;

    // R11 deferred transmitter disable
    wr(3'd2, 8'h18); wr(3'd4, 8'd3); m_div = 3;
    repeat (3) @(negedge clk);
    mclr();
    wr(3'd1, 8'h40);
    wr(3'd0, 8'hE7);
    wr(3'd2, 8'h10);
    chk(pin_oe == 1, "R11 pins held during byte", pin_oe, 1);
    poll(6, ok);
    repeat (3) @(negedge clk);
    chk(pin_oe == 0, "R11 pins released when empty", pin_oe, 0);
    chk(m_tog == 16, "R11 byte completed", m_tog, 16);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule